// File: doc/BRIEF.md
# Wired-to-Message Interrupt Translator

This block takes a wide bank of wired interrupt lines and sends each event out as a single-beat memory write to a remote interrupt controller. The write data carries a small message number. Software picks the number for each line, along with its trigger style, enable and group, through a 32-bit register write port. Two 64-bit target addresses are also programmed there. A write to the "set" address raises the remote interrupt. A write to the "clear" address lowers it.

An edge-style line sends one set message for each rising edge. A level-style line sends a set message when it goes high and a clear message when it goes low. Only lines tagged with the non-secure group (code 0) produce messages. When several lines have events at once, a round-robin arbiter picks which one to send. The chosen message is held in an output register until the downstream ready signal accepts it, and the event stays recorded until it is granted.

Top module: `wmsg_xlate`

## Requirements
- R1: After reset `msg_valid` is low, and no message appears until an enabled line has an event.
- R2: Register writes program the targets and the per-line settings.
  - The set address is written as a low half at byte offset 0x10 and a high half at 0x14.
  - The clear address is written as a low half at 0x18 and a high half at 0x1C.
  - Line i is configured at 0x100 + 4*i. In that word, bit 24 is enable, bit 28 selects edge mode (1) or level mode (0), bits 31:29 are the group, and bits 6:0 are the message number.
- R3: An enabled group-0 edge line sends exactly one write to the set address per rising edge, with data equal to its message number. Its falling edge sends nothing.
  - Rising edges that occur while that line's previous edge is still ungranted merge into one message.
- R4: An enabled group-0 level line sends one set write when it rises. It sends nothing more while it stays high, and one clear write when it falls. Both writes carry its message number.
- R5: A line whose enable bit is 0, including a line whose configuration word is all zeros, produces no messages.
- R6: A line whose group is not 0 produces no messages.
- R7: If a level line's set message has been sent and the line is then disabled while still high, one clear write is sent. It carries the message number that the set write used.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady. No pending event is dropped under backpressure.
- R9: Among lines with events pending at the same time, grants go in ascending index order, starting with the first index above the last line granted and wrapping past the top index.
- R10: With the output idle, an input change applied before clock edge k shows `msg_valid` high after edge k+1.
- R11: `msg_data` bits above the 7-bit message number are always zero. Message number 127 is carried intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN (207) | Wired interrupt lines, one bit per line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW (12) | Register byte address |
| reg_wdata | input | DW (32) | Register write data |
| msg_valid | output | 1 | Outgoing message write is valid |
| msg_ready | input | 1 | Downstream accepts the message this cycle |
| msg_addr | output | 2*DW (64) | Target address (set or clear) |
| msg_data | output | DW (32) | Message number, zero-extended |

## Verification
A new event can arrive in the same cycle that the output register is held by backpressure. The rotating grant pointer then decides which of several pending lines goes next. The bench provokes this by driving three edge lines high together while `msg_ready` is low and the pointer sits in the middle of the range. Releasing ready must then deliver the three messages in wrapped order with nothing lost. A second overlap comes from a configuration write that disables a level line in the same cycle the line's state is being tracked. It is judged by requiring exactly one clear carrying the old message number. A behavioural reference model is compared against the outputs on every cycle.

// File: rtl/wmsg_pkg.sv
`timescale 1ns/1ps
package wmsg_pkg;
   // register byte offsets
   localparam int ADR_SET_LO  = 'h10;
   localparam int ADR_SET_HI  = 'h14;
   localparam int ADR_CLR_LO  = 'h18;
   localparam int ADR_CLR_HI  = 'h1C;
   localparam int ADR_CFG_BASE = 'h100;
   // configuration word fields
   localparam int CFG_EN_BIT   = 24;
   localparam int CFG_EDGE_BIT = 28;
   localparam int CFG_GRP_LSB  = 29;
   localparam int GRP_W        = 3;
   localparam logic [GRP_W-1:0] GRP_MSG = 3'd0;
endpackage

// File: rtl/wmsg_regs.sv
`timescale 1ns/1ps
module wmsg_regs
   import wmsg_pkg::*;
#(
   parameter int NUM_IN = 207,
   parameter int MSG_W  = 7,
   parameter int DW     = 32,
   parameter int RAW    = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr,
   input  logic [RAW-1:0]                 waddr,
   input  logic [DW-1:0]                  wdata,
   output logic [2*DW-1:0]                set_addr,
   output logic [2*DW-1:0]                clr_addr,
   output logic [NUM_IN-1:0]              cfg_en,
   output logic [NUM_IN-1:0]              cfg_edge,
   output logic [NUM_IN-1:0][GRP_W-1:0]   cfg_grp,
   output logic [NUM_IN-1:0][MSG_W-1:0]   cfg_num
);
   localparam int CFG_END = ADR_CFG_BASE + 4 * NUM_IN;

   if (CFG_END > (1 << RAW)) begin : g_bad_raw
      $error("RAW too narrow for NUM_IN configuration words");
   end
   if (CFG_GRP_LSB + GRP_W > DW || MSG_W > CFG_EN_BIT) begin : g_bad_dw
      $error("configuration fields do not fit DW");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_addr <= '0;
         clr_addr <= '0;
      end else if (wr) begin
         if (waddr == RAW'(ADR_SET_LO)) set_addr[DW-1:0]    <= wdata;
         if (waddr == RAW'(ADR_SET_HI)) set_addr[2*DW-1:DW] <= wdata;
         if (waddr == RAW'(ADR_CLR_LO)) clr_addr[DW-1:0]    <= wdata;
         if (waddr == RAW'(ADR_CLR_HI)) clr_addr[2*DW-1:DW] <= wdata;
      end
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_cfg
      localparam logic [RAW-1:0] MY_ADR = RAW'(ADR_CFG_BASE + 4 * i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_en[i]   <= 1'b0;
            cfg_edge[i] <= 1'b0;
            cfg_grp[i]  <= '0;
            cfg_num[i]  <= '0;
         end else if (wr && waddr == MY_ADR) begin
            cfg_en[i]   <= wdata[CFG_EN_BIT];
            cfg_edge[i] <= wdata[CFG_EDGE_BIT];
            cfg_grp[i]  <= wdata[CFG_GRP_LSB +: GRP_W];
            cfg_num[i]  <= wdata[MSG_W-1:0];
         end
      end
   end
endmodule

// File: rtl/wmsg_line.sv
`timescale 1ns/1ps
module wmsg_line #(
   parameter int MSG_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq,
   input  logic             en,
   input  logic             edge_mode,
   input  logic             grp_ok,
   input  logic [MSG_W-1:0] num,
   input  logic             take,
   output logic             req,
   output logic             kind_set,
   output logic [MSG_W-1:0] out_num
);
   logic             irq_q;
   logic             pend;
   logic             sent;
   logic [MSG_W-1:0] held;
   logic             edge_act;
   logic             want;

   assign edge_act = en & edge_mode & grp_ok;
   assign want     = irq_q & en & ~edge_mode & grp_ok;
   assign req      = pend | (sent ^ want);
   assign kind_set = pend | want;
   assign out_num  = kind_set ? num : held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         pend  <= 1'b0;
         sent  <= 1'b0;
         held  <= '0;
      end else begin
         irq_q <= irq;
         pend  <= ((pend & ~take) | (irq & ~irq_q)) & edge_act;
         if (take && !pend) begin
            sent <= want;
            if (want) held <= num;
         end
      end
   end
endmodule

// File: rtl/wmsg_rr_arb.sv
`timescale 1ns/1ps
module wmsg_rr_arb #(
   parameter int N = 207,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic [IW-1:0] grant_idx,
   output logic          any
);
   logic [IW-1:0] ptr;
   logic [IW-1:0] idx_hi, idx_lo;
   logic          found_hi, found_lo;

   always_comb begin
      found_hi = 1'b0;
      found_lo = 1'b0;
      idx_hi   = '0;
      idx_lo   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found_lo) begin
            found_lo = 1'b1;
            idx_lo   = IW'(i);
         end
         if (req[i] && (IW'(i) > ptr) && !found_hi) begin
            found_hi = 1'b1;
            idx_hi   = IW'(i);
         end
      end
      grant_idx = found_hi ? idx_hi : idx_lo;
      any       = found_lo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= IW'(N - 1);
      else if (adv) ptr <= grant_idx;
   end
endmodule

// File: rtl/wmsg_xlate.sv
`timescale 1ns/1ps
module wmsg_xlate
   import wmsg_pkg::*;
#(
   parameter int NUM_IN = 207,
   parameter int MSG_W  = 7,
   parameter int DW     = 32,
   parameter int RAW    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] irq_in,
   input  logic              reg_wr,
   input  logic [RAW-1:0]    reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [2*DW-1:0]   msg_addr,
   output logic [DW-1:0]     msg_data
);
   localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

   if (NUM_IN < 1 || MSG_W < 1 || MSG_W > DW) begin : g_bad_param
      $error("illegal NUM_IN/MSG_W/DW combination");
   end

   logic [2*DW-1:0]                  set_addr, clr_addr;
   logic [NUM_IN-1:0]                cfg_en, cfg_edge;
   logic [NUM_IN-1:0][GRP_W-1:0]     cfg_grp;
   logic [NUM_IN-1:0][MSG_W-1:0]     cfg_num;
   logic [NUM_IN-1:0]                req, kind_set, take;
   logic [NUM_IN-1:0][MSG_W-1:0]     line_num;
   logic [IW-1:0]                    grant_idx;
   logic                             any, load;

   wmsg_regs #(.NUM_IN(NUM_IN), .MSG_W(MSG_W), .DW(DW), .RAW(RAW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_addr), .wdata(reg_wdata),
      .set_addr(set_addr), .clr_addr(clr_addr), .cfg_en(cfg_en),
      .cfg_edge(cfg_edge), .cfg_grp(cfg_grp), .cfg_num(cfg_num)
   );

   for (genvar i = 0; i < NUM_IN; i++) begin : g_line
      wmsg_line #(.MSG_W(MSG_W)) u_line (
         .clk(clk), .rst_n(rst_n), .irq(irq_in[i]), .en(cfg_en[i]),
         .edge_mode(cfg_edge[i]), .grp_ok(cfg_grp[i] == GRP_MSG),
         .num(cfg_num[i]), .take(take[i]), .req(req[i]),
         .kind_set(kind_set[i]), .out_num(line_num[i])
      );
   end

   wmsg_rr_arb #(.N(NUM_IN)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req), .adv(load),
      .grant_idx(grant_idx), .any(any)
   );

   assign load = any & (~msg_valid | msg_ready);

   always_comb begin
      take = '0;
      if (load) take[grant_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (load) begin
         msg_valid <= 1'b1;
         msg_addr  <= kind_set[grant_idx] ? set_addr : clr_addr;
         msg_data  <= DW'(line_num[grant_idx]);
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/wmsg_xlate_chk.sv
`timescale 1ns/1ps
module wmsg_xlate_chk #(
   parameter int DW    = 32,
   parameter int MSG_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            msg_valid,
   input logic            msg_ready,
   input logic [2*DW-1:0] msg_addr,
   input logic [DW-1:0]   msg_data,
   input logic [2*DW-1:0] set_addr,
   input logic [2*DW-1:0] clr_addr
);
   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !msg_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

   assert_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && (!$past(msg_valid) || $past(msg_ready)) &&
      $stable(set_addr) && $stable(clr_addr)
      |-> (msg_addr == set_addr) || (msg_addr == clr_addr));

   assert_data_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_data >> MSG_W) == '0);
endmodule

bind wmsg_xlate wmsg_xlate_chk #(.DW(DW), .MSG_W(MSG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
   .msg_addr(msg_addr), .msg_data(msg_data),
   .set_addr(set_addr), .clr_addr(clr_addr)
);

// File: tb/wmsg_xlate_test.sv
`timescale 1ns/1ps
module wmsg_xlate_test;
   localparam int NI = 207;
   localparam logic [63:0] SETA = 64'h0000_00AB_1234_5000;
   localparam logic [63:0] CLRA = 64'h0000_00AB_1234_5008;
   localparam logic [31:0] EN = 32'h0100_0000;
   localparam logic [31:0] ED = 32'h1000_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] irq = '0;
   logic          reg_wr = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          msg_ready = 1'b1;
   logic          msg_valid;
   logic [63:0]   msg_addr;
   logic [31:0]   msg_data;

   int n_chk = 0;
   int n_err = 0;
   int cycles = 0;
   logic [63:0] log_a[$];
   logic [31:0] log_d[$];

   always #4 clk = ~clk;

   wmsg_xlate uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data)
   );

   // ---------------- behavioural reference model ----------------
   bit          m_q[NI], m_p[NI], m_s[NI], m_en[NI], m_ed[NI];
   int          m_gr[NI], m_num[NI], m_held[NI];
   logic [63:0] m_sa, m_ca, m_a;
   logic [31:0] m_d;
   bit          m_v;
   int          m_ptr;

   function automatic bit m_want(int j);
      return m_q[j] && m_en[j] && !m_ed[j] && m_gr[j] == 0;
   endfunction

   always @(posedge clk) begin : model
      bit free, ks, w, act, rise, np;
      int sel, j;
      cycles++;
      if (!rst_n) begin
         for (int k = 0; k < NI; k++) begin
            m_q[k] = 0; m_p[k] = 0; m_s[k] = 0; m_en[k] = 0; m_ed[k] = 0;
            m_gr[k] = 0; m_num[k] = 0; m_held[k] = 0;
         end
         m_sa = '0; m_ca = '0; m_a = '0; m_d = '0; m_v = 0; m_ptr = NI - 1;
      end else begin
         free = !m_v || msg_ready;
         sel = -1;
         if (free) begin
            for (int k = 1; k <= NI; k++) begin
               j = (m_ptr + k) % NI;
               if (sel < 0 && (m_p[j] || (m_s[j] != m_want(j)))) sel = j;
            end
            if (sel >= 0) begin
               ks = m_p[sel] || m_want(sel);
               m_v = 1;
               m_a = ks ? m_sa : m_ca;
               m_d = ks ? 32'(m_num[sel]) : 32'(m_held[sel]);
               m_ptr = sel;
            end else m_v = 0;
         end
         for (int k = 0; k < NI; k++) begin
            w = m_want(k);
            act = m_en[k] && m_ed[k] && m_gr[k] == 0;
            rise = irq[k] && !m_q[k];
            np = ((m_p[k] && sel != k) || rise) && act;
            if (sel == k && !m_p[k]) begin
               m_s[k] = w;
               if (w) m_held[k] = m_num[k];
            end
            m_p[k] = np;
            m_q[k] = irq[k];
         end
         if (reg_wr) begin
            case (reg_addr)
               12'h010: m_sa[31:0]  = reg_wdata;
               12'h014: m_sa[63:32] = reg_wdata;
               12'h018: m_ca[31:0]  = reg_wdata;
               12'h01C: m_ca[63:32] = reg_wdata;
               default: if (reg_addr >= 12'h100 && reg_addr < 12'h100 + 4 * NI) begin
                  j = (int'(reg_addr) - 'h100) / 4;
                  m_en[j]  = reg_wdata[24];
                  m_ed[j]  = reg_wdata[28];
                  m_gr[j]  = int'(reg_wdata[31:29]);
                  m_num[j] = int'(reg_wdata[6:0]);
               end
            endcase
         end
      end
   end

   // every-cycle comparison and message log, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         n_chk++;
         if (msg_valid !== m_v || (m_v && (msg_addr !== m_a || msg_data !== m_d))) begin
            n_err++;
            $display("FAIL R8 model compare: got v=%0b a=%h d=%0d expected v=%0b a=%h d=%0d",
                     msg_valid, msg_addr, msg_data, m_v, m_a, m_d);
         end
         if (msg_valid && msg_ready) begin
            log_a.push_back(msg_addr);
            log_d.push_back(msg_data);
         end
      end
   end

   always @(posedge clk) begin
      if (cycles > 20000) begin
         n_err++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wreg(logic [11:0] a, logic [31:0] d);
      @(posedge clk); #2;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_wr = 1'b0;
   endtask

   task automatic clear_log();
      log_a.delete();
      log_d.delete();
   endtask

   task automatic cfg(int i, logic [31:0] d);
      wreg(12'(32'h100 + 4 * i), d);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      check("R1 idle after reset", 64'(msg_valid), 64'd0);

      wreg(12'h010, SETA[31:0]);
      wreg(12'h014, SETA[63:32]);
      wreg(12'h018, CLRA[31:0]);
      wreg(12'h01C, CLRA[63:32]);
      cyc(3);
      check("R1 no message without events", 64'(log_a.size()), 64'd0);

      // edge line 5, number 17; latency check
      cfg(5, EN | ED | 32'd17);
      cyc(2);
      irq[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R10 not yet valid after edge k", 64'(msg_valid), 64'd0);
      @(negedge clk);
      check("R10 valid after edge k+1", 64'(msg_valid), 64'd1);
      cyc(4);
      check("R3 one set per rising edge", 64'(log_a.size()), 64'd1);
      check("R3 set address (R2 offsets)", log_a[0], SETA);
      check("R3 data is message number", 64'(log_d[0]), 64'd17);
      irq[5] = 1'b0;
      cyc(5);
      check("R3 no clear on falling edge", 64'(log_a.size()), 64'd1);
      clear_log();
      irq[5] = 1'b1; cyc(5); irq[5] = 1'b0; cyc(5);
      check("R3 second edge gives one more", 64'(log_a.size()), 64'd1);
      clear_log();

      // level line 206, number 127
      cfg(206, EN | 32'd127);
      cyc(2);
      irq[206] = 1'b1;
      cyc(8);
      check("R4 one set while high", 64'(log_a.size()), 64'd1);
      if (log_a.size() > 0) check("R11 data 127 intact", 64'(log_d[0]), 64'd127);
      irq[206] = 1'b0;
      cyc(5);
      check("R4 clear on fall count", 64'(log_a.size()), 64'd2);
      if (log_a.size() > 1) begin
         check("R4 clear address", log_a[1], CLRA);
         check("R4 clear data", 64'(log_d[1]), 64'd127);
      end
      clear_log();

      // disabled lines
      cfg(100, 32'd0);
      irq[100] = 1'b1; cyc(4); irq[100] = 1'b0; cyc(4);
      check("R5 zero config no messages", 64'(log_a.size()), 64'd0);
      cfg(100, ED | 32'd3);
      irq[100] = 1'b1; cyc(4); irq[100] = 1'b0; cyc(4);
      check("R5 enable clear no messages", 64'(log_a.size()), 64'd0);

      // non-zero groups
      cfg(0, EN | 32'h2000_0000 | 32'd9);
      irq[0] = 1'b1; cyc(5); irq[0] = 1'b0; cyc(4);
      check("R6 group 1 level silent", 64'(log_a.size()), 64'd0);
      cfg(0, EN | ED | 32'h8000_0000 | 32'd9);
      irq[0] = 1'b1; cyc(5); irq[0] = 1'b0; cyc(4);
      check("R6 group 4 edge silent", 64'(log_a.size()), 64'd0);

      // disable while level message active
      irq[206] = 1'b1;
      cyc(5);
      cfg(206, 32'd0);
      cyc(5);
      check("R7 set then clear count", 64'(log_a.size()), 64'd2);
      if (log_a.size() > 1) begin
         check("R7 clear address", log_a[1], CLRA);
         check("R7 clear keeps old number", 64'(log_d[1]), 64'd127);
      end
      irq[206] = 1'b0;
      cyc(5);
      check("R5 disabled line fall silent", 64'(log_a.size()), 64'd2);
      clear_log();

      // round robin under backpressure
      cfg(0, EN | ED | 32'd1);
      cfg(5, EN | ED | 32'd2);
      cfg(100, EN | ED | 32'd3);
      irq[5] = 1'b1; cyc(5); irq[5] = 1'b0; cyc(3);
      clear_log();
      msg_ready = 1'b0;
      irq[0] = 1'b1; irq[5] = 1'b1; irq[100] = 1'b1;
      cyc(10);
      check("R8 nothing accepted while stalled", 64'(log_a.size()), 64'd0);
      check("R8 valid held while stalled", 64'(msg_valid), 64'd1);
      msg_ready = 1'b1;
      cyc(8);
      check("R8 all three delivered", 64'(log_a.size()), 64'd3);
      if (log_a.size() == 3) begin
         check("R9 first grant above pointer", 64'(log_d[0]), 64'd3);
         check("R9 wraps to lowest", 64'(log_d[1]), 64'd1);
         check("R9 last is pointer line", 64'(log_d[2]), 64'd2);
      end
      irq[0] = 1'b0; irq[5] = 1'b0; irq[100] = 1'b0;
      cyc(5);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule